// File: doc/BRIEF.md
# GPIO Interrupt Cause Aggregator

This block turns a 32-bit GPIO input vector into four interrupt lines. The vector has already been corrected for polarity upstream. Each pin feeds two independent interrupt paths:

- **Level path.** The pin's current value is gated by a per-pin level enable.
- **Edge path.** A per-pin sticky cause bit records every low-to-high change of the pin. That bit is gated by a per-pin edge enable.

The two gated terms of a pin are ORed together. The pins are then ORed in groups of eight, giving one registered summary line per group.

Software reaches the block through a simple register bus with a select, a write strobe, a byte address and a 32-bit data word. It reads and writes the edge enable and the level enable. It reads the cause register, and it acknowledges edges by writing zeros to the cause register. Address decoding is a small set of named selections:

- CAUSE
- EDGE_EN
- LEVEL_EN
- NONE (unmapped)

The registered read path moves from its idle output to a data cycle for exactly one cycle after each read request.

Top module: `gpio_irq_aggregator`

## Requirements
- R1: After reset the cause, edge-enable and level-enable registers all read as zero and all four interrupt outputs are low.
- R2: A pin whose input is 1 in a cycle and was 0 in the previous cycle sets its cause bit at that clock edge; the cause register is read at byte address 0x14, bit n holding pin n.
- R3: A write to address 0x14 clears every cause bit whose data bit is 0 and leaves every cause bit whose data bit is 1 unchanged.
- R4: When a new rising edge and a clearing write reach the same cause bit at the same clock edge, the bit ends up set.
- R5: The level term of pin n is input n ANDed with level-enable bit n; a change of the level term reaches its interrupt output at the next clock edge.
- R6: The edge term of pin n is cause bit n ANDed with edge-enable bit n; a cause bit with its enable at 0 raises no interrupt.
- R7: Interrupt output g (bit g of irq_out) is the registered OR of the interrupt terms of pins 8g to 8g+7.
- R8: The edge enable is read and written at 0x18 + MASK_OFS and the level enable at 0x1C + MASK_OFS (MASK_OFS defaults to 0); writes to them leave the cause register unchanged.
- R9: A falling input, or an input held high, never sets a cause bit; after clearing, a bit whose pin stays high stays 0.
- R10: Read data appears on bus_rdata in the cycle after the read request and is zero for an unmapped address; a write to an unmapped address changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 32 | Polarity-adjusted GPIO input vector |
| bus_sel | input | 1 | Register access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| irq_out | output | 4 | Registered group interrupts, active high |

## Verification
Faults in internal state show up at the ports in two ways.

A wrong sticky cause bit is visible at the next cause read. It also reaches the matching interrupt output one clock after the cause register settles, so a missed or spurious edge shows up at irq_out two edges after the input change.

A corrupted enable bit turns a level input into a stuck-high or missing interrupt one edge after the pin moves. A read-back exposes the corrupted bit at once. The directed scenarios aim at the points where these paths interact: a clear and an edge on the same cycle, a partial clear, a pin held high across a clear, and each group boundary.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int OFS_CAUSE    = 'h14;
    localparam int OFS_EDGE_EN  = 'h18;
    localparam int OFS_LEVEL_EN = 'h1C;

    typedef enum logic [1:0] {
        SEL_NONE     = 2'd0,
        SEL_CAUSE    = 2'd1,
        SEL_EDGE_EN  = 2'd2,
        SEL_LEVEL_EN = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gia_decode.sv
module gia_decode
    import gpio_irq_pkg::*;
#(
    parameter int AW       = 8,
    parameter int MASK_OFS = 0
) (
    input  logic [AW-1:0] addr,
    output reg_sel_e      sel
);
    localparam logic [AW-1:0] A_CAUSE = AW'(OFS_CAUSE);
    localparam logic [AW-1:0] A_EEN   = AW'(OFS_EDGE_EN + MASK_OFS);
    localparam logic [AW-1:0] A_LEN   = AW'(OFS_LEVEL_EN + MASK_OFS);

    always_comb begin
        if (addr == A_CAUSE)      sel = SEL_CAUSE;
        else if (addr == A_EEN)   sel = SEL_EDGE_EN;
        else if (addr == A_LEN)   sel = SEL_LEVEL_EN;
        else                      sel = SEL_NONE;
    end
endmodule

// File: rtl/gia_edge_cause.sv
module gia_edge_cause #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_in,
    input  logic         clr_en,
    input  logic [N-1:0] keep_word,
    output logic [N-1:0] cause_q
);
    logic [N-1:0] prev_q;
    logic [N-1:0] rise;
    logic [N-1:0] keep;

    assign rise = pin_in & ~prev_q;
    assign keep = clr_en ? keep_word : {N{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '0;
            cause_q <= '0;
        end else begin
            prev_q  <= pin_in;
            cause_q <= (cause_q & keep) | rise;
        end
    end

    // R2 / R4: a detected rise is set on the next cycle, even against a clear
    p_rise_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_in & ~prev_q) != '0) |=>
        ((cause_q & $past(pin_in & ~prev_q)) == $past(pin_in & ~prev_q)));

    // R9: a bit only goes from 0 to 1 on a rise
    p_no_spurious_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause_q & ~$past(cause_q) & ~$past(pin_in & ~prev_q)) == '0));

    // R3: a zero written clears its bit unless a rise arrives together
    p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((cause_q & ~$past(keep_word) & ~$past(pin_in & ~prev_q)) == '0));

    // R3: bits written as one keep their value absent a rise
    p_keep_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> (((cause_q ^ $past(cause_q)) & $past(keep_word)
                     & ~$past(pin_in & ~prev_q)) == '0));
endmodule

// File: rtl/gia_enable_reg.sv
module gia_enable_reg #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] value_q
);
    always_ff @(posedge clk) begin
        if (!rst_n)      value_q <= '0;
        else if (wr_en)  value_q <= wdata;
    end

    // R8: the register only moves on a write
    p_hold_unwritten_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(value_q));
endmodule

// File: rtl/gia_group_or.sv
module gia_group_or #(
    parameter int N  = 32,
    parameter int GW = 8,
    localparam int NG = N / GW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  pend,
    output logic [NG-1:0] irq_q
);
    for (genvar g = 0; g < NG; g++) begin : g_grp
        always_ff @(posedge clk) begin
            if (!rst_n) irq_q[g] <= 1'b0;
            else        irq_q[g] <= |pend[g*GW +: GW];
        end
    end
endmodule

// File: rtl/gpio_irq_aggregator.sv
module gpio_irq_aggregator
    import gpio_irq_pkg::*;
#(
    parameter int N        = 32,
    parameter int GW       = 8,
    parameter int AW       = 8,
    parameter int MASK_OFS = 0,
    localparam int NG      = N / GW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  pin_in,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [N-1:0]  bus_wdata,
    output logic [N-1:0]  bus_rdata,
    output logic [NG-1:0] irq_out
);
    reg_sel_e     sel;
    logic [N-1:0] cause_q;
    logic [N-1:0] edge_en_q;
    logic [N-1:0] level_en_q;
    logic [N-1:0] pend;
    logic         wr_cause, wr_een, wr_len, rd_req;
    logic [N-1:0] rd_mux;

    gia_decode #(.AW(AW), .MASK_OFS(MASK_OFS)) u_dec (
        .addr(bus_addr), .sel(sel));

    assign wr_cause = bus_sel &  bus_wr & (sel == SEL_CAUSE);
    assign wr_een   = bus_sel &  bus_wr & (sel == SEL_EDGE_EN);
    assign wr_len   = bus_sel &  bus_wr & (sel == SEL_LEVEL_EN);
    assign rd_req   = bus_sel & ~bus_wr;

    gia_edge_cause #(.N(N)) u_cause (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .clr_en(wr_cause), .keep_word(bus_wdata), .cause_q(cause_q));

    gia_enable_reg #(.N(N)) u_een (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_een),
        .wdata(bus_wdata), .value_q(edge_en_q));

    gia_enable_reg #(.N(N)) u_len (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_len),
        .wdata(bus_wdata), .value_q(level_en_q));

    assign pend = (pin_in & level_en_q) | (cause_q & edge_en_q);

    gia_group_or #(.N(N), .GW(GW)) u_grp (
        .clk(clk), .rst_n(rst_n), .pend(pend), .irq_q(irq_out));

    always_comb begin
        unique case (sel)
            SEL_CAUSE:    rd_mux = cause_q;
            SEL_EDGE_EN:  rd_mux = edge_en_q;
            SEL_LEVEL_EN: rd_mux = level_en_q;
            default:      rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (rd_req) bus_rdata <= rd_mux;
        else             bus_rdata <= '0;
    end

    // R6 / R5: with both enables clear, no interrupt can follow
    p_masked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_en_q == '0 && level_en_q == '0) |=> (irq_out == '0));

    // R10: an unmapped read returns zero
    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && sel == SEL_NONE) |=> (bus_rdata == '0));

    // R10: with no read request the data bus stays idle at zero
    p_idle_rdata_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> (bus_rdata == '0));
endmodule

// File: tb/sim_gpio_irq_aggregator.sv
module sim_gpio_irq_aggregator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin_in = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [7:0] A_CAUSE = 8'h14;
    localparam logic [7:0] A_EEN   = 8'h18;
    localparam logic [7:0] A_LEN   = 8'h1C;

    always #2 clk = ~clk;

    gpio_irq_aggregator u0 (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out));

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clean();
        pin_in = '0;
        tick(1);
        wr(A_EEN, '0);
        wr(A_LEN, '0);
        wr(A_CAUSE, '0);
        tick(2);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 irq after reset", {28'd0, irq_out}, 32'd0);
        rd(A_CAUSE, d); chk("R1 cause reset", d, 32'd0);
        rd(A_EEN, d);   chk("R1 edge enable reset", d, 32'd0);
        rd(A_LEN, d);   chk("R1 level enable reset", d, 32'd0);
    endtask

    task automatic t_edge_capture();
        logic [31:0] d;
        clean();
        pin_in = 32'h0000_0008;
        tick(2);
        rd(A_CAUSE, d); chk("R2 rise sets bit 3", d, 32'h8);
        pin_in = '0;
        tick(2);
        rd(A_CAUSE, d); chk("R9 fall sets nothing", d, 32'h8);
        pin_in = 32'h0000_0020;
        tick(2);
        wr(A_CAUSE, '0);
        tick(2);
        rd(A_CAUSE, d); chk("R9 held high stays clear", d, 32'h0);
    endtask

    task automatic t_partial_clear();
        logic [31:0] d;
        clean();
        pin_in = 32'h0000_0007;
        tick(2);
        wr(A_CAUSE, 32'hFFFF_FFFD);
        rd(A_CAUSE, d); chk("R3 partial clear", d, 32'h5);
        wr(A_CAUSE, 32'h0);
        rd(A_CAUSE, d); chk("R3 full clear", d, 32'h0);
    endtask

    task automatic t_collision();
        logic [31:0] d;
        clean();
        pin_in = 32'h0000_0040;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_CAUSE; bus_wdata = '0;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        rd(A_CAUSE, d); chk("R4 edge beats clear", d, 32'h40);
    endtask

    task automatic t_enables();
        logic [31:0] d;
        clean();
        pin_in = 32'h0000_0100;
        tick(2);
        wr(A_EEN, 32'hA5A5_A5A4);
        wr(A_LEN, 32'h0F0F_0000);
        rd(A_EEN, d);   chk("R8 edge enable readback", d, 32'hA5A5_A5A4);
        rd(A_LEN, d);   chk("R8 level enable readback", d, 32'h0F0F_0000);
        rd(A_CAUSE, d); chk("R8 cause untouched by enable writes", d, 32'h100);
        wr(8'h40, 32'h0);
        rd(A_CAUSE, d); chk("R10 unmapped write ignored", d, 32'h100);
        rd(8'h40, d);   chk("R10 unmapped read zero", d, 32'h0);
        rd(A_LEN, d);   chk("R10 enable unchanged by unmapped write", d, 32'h0F0F_0000);
    endtask

    task automatic t_level();
        clean();
        wr(A_LEN, 32'h0000_0200);
        pin_in = 32'h0000_0200;
        tick(1);
        chk("R5 level raises group 1", {28'd0, irq_out}, 32'h2);
        pin_in = '0;
        tick(1);
        chk("R5 level drop clears group 1", {28'd0, irq_out}, 32'h0);
        pin_in = 32'h0000_0400;
        tick(1);
        chk("R5 disabled level pin quiet", {28'd0, irq_out}, 32'h0);
    endtask

    task automatic t_groups();
        clean();
        wr(A_LEN, 32'hFFFF_FFFF);
        for (int g = 0; g < 4; g++) begin
            pin_in = '0;
            pin_in[g*8 + (g % 2 == 0 ? 0 : 7)] = 1'b1;
            tick(1);
            chk("R7 one pin one group", {28'd0, irq_out}, 32'(1 << g));
        end
        pin_in = 32'h8000_0001;
        tick(1);
        chk("R7 two groups at once", {28'd0, irq_out}, 32'h9);
    endtask

    task automatic t_edge_irq();
        clean();
        wr(A_EEN, 32'h0010_0000);
        pin_in = 32'h0010_0000;
        tick(1);
        chk("R6 edge irq not yet", {28'd0, irq_out}, 32'h0);
        tick(1);
        chk("R6 edge irq group 2", {28'd0, irq_out}, 32'h4);
        pin_in = '0;
        tick(2);
        chk("R6 edge irq sticky after fall", {28'd0, irq_out}, 32'h4);
        wr(A_CAUSE, '0);
        tick(1);
        chk("R6 edge irq cleared", {28'd0, irq_out}, 32'h0);
        pin_in = 32'h0020_0000;
        tick(3);
        chk("R6 disabled edge quiet", {28'd0, irq_out}, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_edge_capture();
        t_partial_clear();
        t_collision();
        t_enables();
        t_level();
        t_groups();
        t_edge_irq();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule